// File: doc/BRIEF.md
# Four-Segment Instruction Pipeline with Flush

This block is a small accumulator processor built as a pipeline of four one-clock segments. In the first segment it reads an instruction word. In the second it decodes that word and forms the effective address. In the third it reads the operand from data storage, and in the fourth it executes. Program storage and data storage are separate, so the first and third segments never compete for a port. In steady state four instructions are in flight at once, each in a different segment. The program image and the initial data image are parameters of the block.

A jump resolves in the execute segment. An accepted interrupt is serviced after the instruction in execute completes. Either event turns the three younger slots into bubbles and restarts fetch at the new address, at a cost of three cycles. An interrupt saves the address at which execution would have continued and forces fetch to a fixed vector. A jump to the all-ones address returns to the saved address. There is no interlock between dependent instructions, so the program must keep one slot between a store and a load of the same word. Only the fetch address and the accumulator are visible at the ports. Results in data storage are observed by loading them back.

Top module: `seg4_cpu`

## Requirements
- R1: While `rst_n` is low, `pc_dbg` reads 0, `acc_dbg` reads 0, every segment holds a bubble, no interrupt is pending and no handler is active.
- R2: In a cycle with no redirect, the fetch address advances by exactly one at the next clock edge. The data read of the third segment never stalls the fetch.
- R3: An instruction fetched in cycle n is executed in cycle n+3, and its effect on `acc_dbg` shows from cycle n+4.
- R4: An instruction word is 16 bits. Bits [15:12] hold the opcode: 0 no-op, 1 load, 2 add, 3 store, 4 jump. Bits [11:0] hold the address. Any other opcode acts as a no-op. The data word index is the low address bits.
- R5: Load copies the data word into the accumulator. Add adds the data word to the accumulator. Store writes the accumulator into the data word at the end of its execute cycle. A load of a just-stored word sees the new value when at least one instruction lies between the store and the load.
- R6: A jump executing in cycle c sets the fetch address to its target in cycle c+1 and discards the three younger instructions. The target's effect therefore shows three cycles later than a sequential successor's would.
- R7: A rising edge on `irq` becomes pending at the next clock edge. It is taken at the end of the next cycle in which execute holds a valid instruction. That instruction completes, the pipe is emptied, fetch moves to 0x010, and the return address is saved. The return address is the jump target if that instruction is a jump, and the next sequential address otherwise.
- R8: A jump to address 0xFFF redirects fetch to the saved return address and ends the handler.
- R9: A rising edge on `irq` that arrives while a handler is active is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq | input | 1 | Interrupt request, edge-detected |
| pc_dbg | output | 12 | Current fetch address |
| acc_dbg | output | 16 | Accumulator |

## Verification
A slot whose valid bit is wrong after a flush shows up on `acc_dbg` four cycles after the redirect. A skipped load of word 0 would overwrite the accumulator there. A wrong fetch address shows on `pc_dbg` in the very next cycle. A lost or doubled interrupt, or a bad return address, shows within about ten cycles: the handler's single increment of the accumulator is missing or repeated, or `pc_dbg` comes back to the wrong loop address. The bench sweeps the interrupt edge across every phase of a four-cycle jump loop, and it also places one edge inside a running handler.

// File: rtl/seg4_pkg.sv
package seg4_pkg;
  localparam int INSN_W = 16;
  localparam int OP_W   = 4;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 16;

  typedef enum logic [OP_W-1:0] {
    OP_NOP   = 4'd0,
    OP_LOAD  = 4'd1,
    OP_ADD   = 4'd2,
    OP_STORE = 4'd3,
    OP_JMP   = 4'd4
  } opcode_e;

  typedef struct packed {
    logic              v;
    logic [ADDR_W-1:0] pc;
    logic [INSN_W-1:0] ir;
  } fetch_slot_t;

  typedef struct packed {
    logic              v;
    logic [ADDR_W-1:0] pc;
    opcode_e           op;
    logic [ADDR_W-1:0] ea;
  } decode_slot_t;

  typedef struct packed {
    logic              v;
    logic [ADDR_W-1:0] pc;
    opcode_e           op;
    logic [ADDR_W-1:0] ea;
    logic [DATA_W-1:0] opnd;
  } operand_slot_t;
endpackage

// File: rtl/seg4_fetch.sv
module seg4_fetch
  import seg4_pkg::*;
#(
  parameter int                         IMEM_DEPTH = 32,
  parameter logic [INSN_W*IMEM_DEPTH-1:0] PROG     = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              redirect,
  input  logic [ADDR_W-1:0] redirect_pc,
  output logic [ADDR_W-1:0] pc,
  output fetch_slot_t       slot
);
  localparam int IDX_W = $clog2(IMEM_DEPTH);

  logic [IDX_W-1:0]  idx;
  logic              in_range;
  logic [INSN_W-1:0] word;

  assign idx      = pc[IDX_W-1:0];
  assign in_range = (pc[ADDR_W-1:IDX_W] == '0);
  assign word     = in_range ? PROG[idx*INSN_W +: INSN_W] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc   <= '0;
      slot <= '0;
    end else begin
      slot.pc <= pc;
      slot.ir <= word;
      if (redirect) begin
        pc     <= redirect_pc;
        slot.v <= 1'b0;
      end else begin
        pc     <= pc + 1'b1;
        slot.v <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/seg4_decode.sv
module seg4_decode
  import seg4_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  fetch_slot_t  in_slot,
  output decode_slot_t slot
);
  opcode_e op_dec;

  always_comb begin
    case (in_slot.ir[INSN_W-1 -: OP_W])
      4'd1:    op_dec = OP_LOAD;
      4'd2:    op_dec = OP_ADD;
      4'd3:    op_dec = OP_STORE;
      4'd4:    op_dec = OP_JMP;
      default: op_dec = OP_NOP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot <= '0;
    end else begin
      slot.v  <= in_slot.v & ~flush;
      slot.pc <= in_slot.pc;
      slot.op <= op_dec;
      slot.ea <= in_slot.ir[ADDR_W-1:0];
    end
  end
endmodule

// File: rtl/seg4_operand.sv
module seg4_operand
  import seg4_pkg::*;
#(
  parameter int                           DMEM_DEPTH = 16,
  parameter logic [DATA_W*DMEM_DEPTH-1:0] DATA_INIT  = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  decode_slot_t      in_slot,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output operand_slot_t     slot
);
  localparam int DIDX_W = $clog2(DMEM_DEPTH);

  logic [DATA_W-1:0] dmem [DMEM_DEPTH];
  logic [DIDX_W-1:0] rd_idx;
  logic [DIDX_W-1:0] wr_idx;

  assign rd_idx = in_slot.ea[DIDX_W-1:0];
  assign wr_idx = wr_addr[DIDX_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DMEM_DEPTH; i++) begin
        dmem[i] <= DATA_INIT[i*DATA_W +: DATA_W];
      end
    end else if (wr_en) begin
      dmem[wr_idx] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot <= '0;
    end else begin
      slot.v    <= in_slot.v & ~flush;
      slot.pc   <= in_slot.pc;
      slot.op   <= in_slot.op;
      slot.ea   <= in_slot.ea;
      slot.opnd <= dmem[rd_idx];
    end
  end
endmodule

// File: rtl/seg4_execute.sv
module seg4_execute
  import seg4_pkg::*;
#(
  parameter logic [ADDR_W-1:0] VECTOR = 12'h010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq,
  input  operand_slot_t     in_slot,
  output logic [DATA_W-1:0] acc,
  output logic              redirect,
  output logic [ADDR_W-1:0] redirect_pc,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              jmp_exec,
  output logic [ADDR_W-1:0] jmp_tgt,
  output logic              take_irq,
  output logic              in_isr,
  output logic              irq_pend
);
  localparam logic [ADDR_W-1:0] RET_ADDR = '1;

  logic              irq_q;
  logic              irq_rise;
  logic              is_ret;
  logic [ADDR_W-1:0] epc;
  logic [ADDR_W-1:0] next_seq;

  assign irq_rise = irq & ~irq_q;
  assign jmp_exec = in_slot.v && (in_slot.op == OP_JMP);
  assign is_ret   = jmp_exec && (in_slot.ea == RET_ADDR);
  assign jmp_tgt  = is_ret ? epc : in_slot.ea;
  assign next_seq = jmp_exec ? jmp_tgt : in_slot.pc + 1'b1;
  assign take_irq = irq_pend && in_slot.v && !in_isr;

  assign redirect    = jmp_exec | take_irq;
  assign redirect_pc = take_irq ? VECTOR : jmp_tgt;

  assign wr_en   = in_slot.v && (in_slot.op == OP_STORE);
  assign wr_addr = in_slot.ea;
  assign wr_data = acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
    end else if (in_slot.v) begin
      case (in_slot.op)
        OP_LOAD: acc <= in_slot.opnd;
        OP_ADD:  acc <= acc + in_slot.opnd;
        default: acc <= acc;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q    <= 1'b0;
      irq_pend <= 1'b0;
      in_isr   <= 1'b0;
      epc      <= '0;
    end else begin
      irq_q    <= irq;
      irq_pend <= (irq_pend & ~take_irq) | (irq_rise & ~in_isr & ~take_irq);
      if (take_irq) begin
        in_isr <= 1'b1;
        epc    <= next_seq;
      end else if (is_ret) begin
        in_isr <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/seg4_cpu.sv
module seg4_cpu
  import seg4_pkg::*;
#(
  parameter int                           IMEM_DEPTH = 32,
  parameter int                           DMEM_DEPTH = 16,
  parameter logic [ADDR_W-1:0]            VECTOR     = 12'h010,
  parameter logic [INSN_W*IMEM_DEPTH-1:0] PROG       = '0,
  parameter logic [DATA_W*DMEM_DEPTH-1:0] DATA_INIT  = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq,
  output logic [ADDR_W-1:0] pc_dbg,
  output logic [DATA_W-1:0] acc_dbg
);
  fetch_slot_t       s1;
  decode_slot_t      s2;
  operand_slot_t     s3;
  logic              redirect;
  logic [ADDR_W-1:0] redirect_pc;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic              jmp_exec;
  logic [ADDR_W-1:0] jmp_tgt;
  logic              take_irq;
  logic              in_isr;
  logic              irq_pend;

  seg4_fetch #(.IMEM_DEPTH(IMEM_DEPTH), .PROG(PROG)) u_fetch (
    .clk(clk), .rst_n(rst_n), .redirect(redirect), .redirect_pc(redirect_pc),
    .pc(pc_dbg), .slot(s1)
  );

  seg4_decode u_decode (
    .clk(clk), .rst_n(rst_n), .flush(redirect), .in_slot(s1), .slot(s2)
  );

  seg4_operand #(.DMEM_DEPTH(DMEM_DEPTH), .DATA_INIT(DATA_INIT)) u_operand (
    .clk(clk), .rst_n(rst_n), .flush(redirect), .in_slot(s2),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .slot(s3)
  );

  seg4_execute #(.VECTOR(VECTOR)) u_execute (
    .clk(clk), .rst_n(rst_n), .irq(irq), .in_slot(s3), .acc(acc_dbg),
    .redirect(redirect), .redirect_pc(redirect_pc),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .jmp_exec(jmp_exec), .jmp_tgt(jmp_tgt), .take_irq(take_irq),
    .in_isr(in_isr), .irq_pend(irq_pend)
  );
endmodule

// File: rtl/seg4_cpu_chk.sv
module seg4_cpu_chk #(
  parameter int               ADDR_W = 12,
  parameter logic [ADDR_W-1:0] VECTOR = 12'h010
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] pc,
  input logic              flush,
  input logic              jmp_exec,
  input logic [ADDR_W-1:0] jmp_tgt,
  input logic              take_irq,
  input logic              in_isr,
  input logic              irq_pend,
  input logic              v1,
  input logic              v2,
  input logic              v3
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_STATE: assert (pc == '0 && !v1 && !v2 && !v3 && !in_isr && !irq_pend); // R1
    end
  end

  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |=> pc == ($past(pc) + 1'b1)); // R2

  AST_JMP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (jmp_exec && !take_irq) |=> pc == $past(jmp_tgt)); // R6

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!v1 && !v2 && !v3)); // R6

  AST_IRQ_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |=> (pc == VECTOR && in_isr)); // R7

  AST_NO_NEST: assert property (@(posedge clk) disable iff (!rst_n)
    in_isr |-> !irq_pend); // R9
endmodule

bind seg4_cpu seg4_cpu_chk #(.ADDR_W(seg4_pkg::ADDR_W), .VECTOR(VECTOR)) u_chk (
  .clk(clk), .rst_n(rst_n), .pc(pc_dbg), .flush(redirect),
  .jmp_exec(jmp_exec), .jmp_tgt(jmp_tgt), .take_irq(take_irq),
  .in_isr(in_isr), .irq_pend(irq_pend),
  .v1(s1.v), .v2(s2.v), .v3(s3.v)
);

// File: tb/seg4_cpu_tb.sv
module seg4_cpu_tb;
  localparam int CLK_PERIOD = 10;
  localparam int IMEM_DEPTH = 32;
  localparam int DMEM_DEPTH = 16;

  function automatic logic [16*IMEM_DEPTH-1:0] build_prog();
    logic [16*IMEM_DEPTH-1:0] p;
    p = '0;
    p[ 0*16 +: 16] = 16'h1001; // load  d1
    p[ 1*16 +: 16] = 16'h2002; // add   d2
    p[ 2*16 +: 16] = 16'h2003; // add   d3
    p[ 3*16 +: 16] = 16'h3008; // store d8
    p[ 4*16 +: 16] = 16'hF123; // unknown opcode, gap slot
    p[ 5*16 +: 16] = 16'h1008; // load  d8
    p[ 6*16 +: 16] = 16'h2008; // add   d8
    p[ 7*16 +: 16] = 16'h400A; // jump 10
    p[ 8*16 +: 16] = 16'h1000; // discarded
    p[ 9*16 +: 16] = 16'h1000; // discarded
    p[10*16 +: 16] = 16'h2001; // add   d1
    p[11*16 +: 16] = 16'h400B; // jump to self
    p[16*16 +: 16] = 16'h2000; // handler: add d0
    p[17*16 +: 16] = 16'h4FFF; // return
    return p;
  endfunction

  function automatic logic [16*DMEM_DEPTH-1:0] build_data();
    logic [16*DMEM_DEPTH-1:0] d;
    for (int i = 0; i < DMEM_DEPTH; i++) d[i*16 +: 16] = 16'(3*i + 1);
    return d;
  endfunction

  localparam logic [16*IMEM_DEPTH-1:0] PROG_IMG = build_prog();
  localparam logic [16*DMEM_DEPTH-1:0] DATA_IMG = build_data();

  logic        clk = 1'b0;
  logic        rst_n;
  logic        irq;
  logic [11:0] pc_dbg;
  logic [15:0] acc_dbg;
  int          checks = 0;
  int          fails  = 0;
  bit          done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg4_cpu #(.IMEM_DEPTH(IMEM_DEPTH), .DMEM_DEPTH(DMEM_DEPTH), .VECTOR(12'h010),
             .PROG(PROG_IMG), .DATA_INIT(DATA_IMG)) u_dut (
    .clk(clk), .rst_n(rst_n), .irq(irq), .pc_dbg(pc_dbg), .acc_dbg(acc_dbg)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_pc(input int k);
    if (k <= 10) return k;
    if (k <= 15) return k - 1;
    return 11 + ((k - 16) % 4);
  endfunction

  // d1=4 d2=7 d3=10; results show four cycles after fetch
  function automatic int exp_acc(input int k);
    if (k < 4)  return 0;
    if (k == 4) return 4;
    if (k == 5) return 11;
    if (k < 10) return 21;
    if (k < 15) return 42;
    return 46;
  endfunction

  task automatic run_irq(input int phase, input bit nest, inout int n_taken);
    int lat;
    int back;
    bit seen16;
    repeat (phase) @(negedge clk);
    irq = 1'b1;
    @(negedge clk);
    irq = 1'b0;
    lat = 0;
    while (pc_dbg != 12'h010 && lat < 8) begin
      @(negedge clk);
      lat++;
    end
    chk("R7 vector reached", int'(pc_dbg), 16);
    if (nest) irq = 1'b1;            // edge inside active handler
    @(negedge clk);
    irq = 1'b0;
    back = 0;
    while (pc_dbg >= 12'h010 && back < 12) begin
      @(negedge clk);
      back++;
    end
    chk("R8 return address", int'(pc_dbg), 11);
    n_taken++;
    seen16 = 1'b0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (pc_dbg == 12'h010) seen16 = 1'b1;
    end
    chk(nest ? "R9 no second entry" : "R7 single entry", int'(seen16), 0);
    chk(nest ? "R9 acc after dropped edge" : "R7 acc after handler",
        int'(acc_dbg), 46 + n_taken);
  endtask

  initial begin
    int n_taken;
    rst_n = 1'b0;
    irq   = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 pc in reset", int'(pc_dbg), 0);
    chk("R1 acc in reset", int'(acc_dbg), 0);
    rst_n = 1'b1;
    for (int k = 0; k < 28; k++) begin
      if (k > 0) @(negedge clk);
      if (k <= 10) chk("R2 pc step", int'(pc_dbg), exp_pc(k));
      else         chk("R6 pc after jump", int'(pc_dbg), exp_pc(k));
      if (k == 8)       chk("R4 unknown opcode no-op", int'(acc_dbg), exp_acc(k));
      else if (k == 9)  chk("R5 load after store gap", int'(acc_dbg), exp_acc(k));
      else if (k >= 11 && k <= 14) chk("R6 discarded slots", int'(acc_dbg), exp_acc(k));
      else              chk("R3 acc timing", int'(acc_dbg), exp_acc(k));
    end
    n_taken = 0;
    for (int p = 0; p < 8; p++) run_irq(p, 1'b0, n_taken);
    run_irq(2, 1'b1, n_taken);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule